// File: doc/BRIEF.md
# Input Protection Switch Sequencer

This block is the synchronous control core of a load switch that shields a downstream supply rail from an input that is too high or too low. Each clock it takes a digitized input-voltage code and decides whether that code lies inside a valid window. The lower edge has its own hysteresis. The upper edge has a separate hysteresis.

When the window is valid and the active-low enable is asserted, a soft-start delay runs before the pass-switch gate enable goes high. A second delay runs after that before the active-low fault flag is released. If the input leaves the window, the switch opens on the very next clock and the flag drops. Enable can shut the switch off but never hides a fault. While the block is disabled, the flag still follows input validity.

Thresholds, hysteresis widths and both delay lengths come from static configuration inputs. The code width and the counter width are parameters. A 3-bit status output exposes the sequencer state.

Top module: `inprot_seq`

## Requirements
- R1: During and directly after a synchronous reset, `gate_on` is 0, `flag_n` is 0 and `status` is 0 (fault). Both detectors start in the invalid state.
- R2: The input is valid only while the lower detector is good and the upper detector is not tripped. The first clock edge that sees an invalid sample puts `status` at 0 and drives `gate_on` and `flag_n` to 0, with no added delay.
- R3: The lower detector becomes good only when `vin > uv_thr + uv_hys`. Once good, it stays good until `vin < uv_thr`.
- R4: The upper detector trips only when `vin > ov_thr`. Once tripped, it stays tripped until `vin < ov_thr - ov_hys`.
- R5: With a valid input and `en_n` low, the sequencer enters the turn-on count (status 2) with `gate_on` 0 and `flag_n` 0. It stays there for max(`t_on`,1) cycles, and then `gate_on` goes to 1.
- R6: After the gate closes, the sequencer waits in status 3 (`gate_on` 1, `flag_n` 0) for max(`t_start`,1) cycles. It then enters status 4, where both `gate_on` and `flag_n` are 1.
- R7: Leaving the window at any point during either delay abandons the sequence. On return, the count restarts from zero.
- R8: With `en_n` high and a valid input, the status is 1, `gate_on` is 0 and `flag_n` is 1. With `en_n` high and an invalid input, the status is 0 and `flag_n` is 0.
- R9: When `en_n` returns low with a valid input, the full turn-on delay followed by the flag delay restarts from zero.
- R10: The status encoding is 0 for fault, 1 for disabled, 2 for turn-on count, 3 for gate closed with the flag pending, and 4 for running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| vin | input | CODE_W | Digitized input-voltage sample |
| uv_thr | input | CODE_W | Lower threshold code |
| uv_hys | input | CODE_W | Lower hysteresis width |
| ov_thr | input | CODE_W | Upper threshold code |
| ov_hys | input | CODE_W | Upper hysteresis width |
| t_on | input | CNT_W | Turn-on delay in cycles |
| t_start | input | CNT_W | Flag-release delay in cycles |
| en_n | input | 1 | Enable, active low (high = shutdown) |
| gate_on | output | 1 | Pass-switch gate enable |
| flag_n | output | 1 | Fault flag, active low |
| status | output | 3 | Sequencer state code |

## Verification
Slow directed ramps test each detector separately. They step through the values one below the switch point, exactly on it and one above it, on both the rising and the falling side, which separates a missing hysteresis from an off-by-one compare. Single-cycle excursions beyond a threshold during each delay show whether a count really restarts or only pauses. Enable toggles with both valid and invalid input show that enable and fault are kept apart. Zero delay settings check the minimum-length case. A long random run then mixes input codes near both thresholds, enable toggles and changing delay values. It is compared cycle by cycle against a bench model of the requirements.

// File: rtl/inprot_pkg.sv
package inprot_pkg;

  typedef enum logic [2:0] {
    ST_FAULT     = 3'd0,
    ST_DISABLED  = 3'd1,
    ST_COUNT_ON  = 3'd2,
    ST_FLAG_WAIT = 3'd3,
    ST_RUN       = 3'd4
  } seq_state_t;

  // strict "above threshold plus margin" compare, done one bit wider
  function automatic logic above_with_margin(logic [31:0] v, logic [31:0] thr,
                                             logic [31:0] margin);
    return {1'b0, v} > ({1'b0, thr} + {1'b0, margin});
  endfunction

  // "below threshold minus margin" without an underflowing subtraction
  function automatic logic below_with_margin(logic [31:0] v, logic [31:0] thr,
                                             logic [31:0] margin);
    return ({1'b0, v} + {1'b0, margin}) < {1'b0, thr};
  endfunction

  // delay phase ends on the cycle where the count reaches max(limit,1)
  function automatic logic delay_done(logic [31:0] cnt, logic [31:0] limit);
    return ({1'b0, cnt} + 33'd1) >= {1'b0, limit};
  endfunction

endpackage

// File: rtl/win_detect.sv
module win_detect
  import inprot_pkg::*;
#(
  parameter int CODE_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] vin,
  input  logic [CODE_W-1:0] uv_thr,
  input  logic [CODE_W-1:0] uv_hys,
  input  logic [CODE_W-1:0] ov_thr,
  input  logic [CODE_W-1:0] ov_hys,
  output logic              win_ok,
  output logic              uv_good_q,
  output logic              ov_trip_q
);

  logic uv_rise_ev, uv_fall_ev, ov_rise_ev, ov_fall_ev;
  logic uv_good_d, ov_trip_d;

  assign uv_rise_ev = above_with_margin(32'(vin), 32'(uv_thr), 32'(uv_hys));
  assign uv_fall_ev = vin < uv_thr;
  assign ov_rise_ev = above_with_margin(32'(vin), 32'(ov_thr), 32'd0);
  assign ov_fall_ev = below_with_margin(32'(vin), 32'(ov_thr), 32'(ov_hys));

  assign uv_good_d = uv_good_q ? !uv_fall_ev : uv_rise_ev;
  assign ov_trip_d = ov_trip_q ? !ov_fall_ev : ov_rise_ev;

  // decision on the current sample, so the sequencer reacts in one edge
  assign win_ok = uv_good_d && !ov_trip_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      uv_good_q <= 1'b0;
      ov_trip_q <= 1'b0;
    end else begin
      uv_good_q <= uv_good_d;
      ov_trip_q <= ov_trip_d;
    end
  end

  // R3
  uv_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(uv_good_q) |-> ({1'b0, $past(vin)} > ({1'b0, $past(uv_thr)} + {1'b0, $past(uv_hys)})));
  // R3
  uv_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(uv_good_q) |-> ($past(vin) < $past(uv_thr)));
  // R4
  ov_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ov_trip_q) |-> ($past(vin) > $past(ov_thr)));

endmodule

// File: rtl/dly_counter.sv
module dly_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (inc && cnt != CNT_MAX) cnt <= cnt + 1'b1;
  end

  // R7
  cnt_clear_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> (cnt == '0));

endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import inprot_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             win_ok,
  input  logic             en_n,
  input  logic [CNT_W-1:0] t_on,
  input  logic [CNT_W-1:0] t_start,
  input  logic [CNT_W-1:0] cnt,
  output logic             cnt_clr,
  output logic             cnt_inc,
  output seq_state_t       state,
  output logic             gate_on,
  output logic             flag_n
);

  seq_state_t state_d;
  logic on_done, start_done;

  assign on_done    = delay_done(32'(cnt), 32'(t_on));
  assign start_done = delay_done(32'(cnt), 32'(t_start));

  always_comb begin
    state_d = state;
    cnt_clr = 1'b0;
    cnt_inc = 1'b0;
    if (!win_ok) begin
      state_d = ST_FAULT;
      cnt_clr = 1'b1;
    end else if (en_n) begin
      state_d = ST_DISABLED;
      cnt_clr = 1'b1;
    end else begin
      unique case (state)
        ST_FAULT, ST_DISABLED: begin
          state_d = ST_COUNT_ON;
          cnt_clr = 1'b1;
        end
        ST_COUNT_ON: begin
          if (on_done) begin
            state_d = ST_FLAG_WAIT;
            cnt_clr = 1'b1;
          end else cnt_inc = 1'b1;
        end
        ST_FLAG_WAIT: begin
          if (start_done) begin
            state_d = ST_RUN;
            cnt_clr = 1'b1;
          end else cnt_inc = 1'b1;
        end
        ST_RUN: state_d = ST_RUN;
        default: begin
          state_d = ST_FAULT;
          cnt_clr = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_FAULT;
    else     state <= state_d;
  end

  assign gate_on = (state == ST_FLAG_WAIT) || (state == ST_RUN);
  assign flag_n  = (state == ST_DISABLED)  || (state == ST_RUN);

  // R2
  fault_gate_off_chk: assert property (@(posedge clk) disable iff (rst)
    !win_ok |=> !gate_on);
  // R2
  fault_flag_low_chk: assert property (@(posedge clk) disable iff (rst)
    !win_ok |=> !flag_n);
  // R8
  shutdown_gate_off_chk: assert property (@(posedge clk) disable iff (rst)
    en_n |=> !gate_on);
  // R5
  gate_from_count_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(gate_on) |-> ($past(state) == ST_COUNT_ON));
  // R6
  run_from_wait_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RUN && $past(state) != ST_RUN) |-> ($past(state) == ST_FLAG_WAIT));

endmodule

// File: rtl/inprot_seq.sv
module inprot_seq
  import inprot_pkg::*;
#(
  parameter int CODE_W = 10,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] vin,
  input  logic [CODE_W-1:0] uv_thr,
  input  logic [CODE_W-1:0] uv_hys,
  input  logic [CODE_W-1:0] ov_thr,
  input  logic [CODE_W-1:0] ov_hys,
  input  logic [CNT_W-1:0]  t_on,
  input  logic [CNT_W-1:0]  t_start,
  input  logic              en_n,
  output logic              gate_on,
  output logic              flag_n,
  output logic [2:0]        status
);

  logic             win_ok, uv_good_q, ov_trip_q;
  logic             cnt_clr, cnt_inc;
  logic [CNT_W-1:0] cnt;
  seq_state_t       state;

  win_detect #(.CODE_W(CODE_W)) u_win (
    .clk(clk), .rst(rst), .vin(vin),
    .uv_thr(uv_thr), .uv_hys(uv_hys), .ov_thr(ov_thr), .ov_hys(ov_hys),
    .win_ok(win_ok), .uv_good_q(uv_good_q), .ov_trip_q(ov_trip_q)
  );

  dly_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .clr(cnt_clr), .inc(cnt_inc), .cnt(cnt)
  );

  seq_ctrl #(.CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst(rst), .win_ok(win_ok), .en_n(en_n),
    .t_on(t_on), .t_start(t_start), .cnt(cnt),
    .cnt_clr(cnt_clr), .cnt_inc(cnt_inc), .state(state),
    .gate_on(gate_on), .flag_n(flag_n)
  );

  assign status = state;

  // R10
  status_range_chk: assert property (@(posedge clk) disable iff (rst)
    status <= 3'd4);
  // R1
  reset_state_chk: assert property (@(posedge clk)
    $past(rst) |-> (status == 3'd0 && !uv_good_q && !ov_trip_q));

endmodule

// File: tb/test_inprot_seq.sv
module test_inprot_seq;
  localparam int CLK_PERIOD = 10;
  localparam int CODE_W = 10;
  localparam int CNT_W  = 16;

  logic clk = 1'b0, rst = 1'b1, en_n = 1'b0;
  logic [CODE_W-1:0] vin = '0, uv_thr = 10'd300, uv_hys = 10'd20;
  logic [CODE_W-1:0] ov_thr = 10'd700, ov_hys = 10'd30;
  logic [CNT_W-1:0]  t_on = 16'd6, t_start = 16'd4;
  logic gate_on, flag_n;
  logic [2:0] status;

  int errors = 0, checks = 0;
  bit finished = 0;
  string tag = "R1";

  // bench model state
  bit m_uv = 0, m_ov = 0;
  int m_st = 0, m_age = 0;

  inprot_seq #(.CODE_W(CODE_W), .CNT_W(CNT_W)) i_inprot_seq (
    .clk(clk), .rst(rst), .vin(vin), .uv_thr(uv_thr), .uv_hys(uv_hys),
    .ov_thr(ov_thr), .ov_hys(ov_hys), .t_on(t_on), .t_start(t_start),
    .en_n(en_n), .gate_on(gate_on), .flag_n(flag_n), .status(status)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic bit lower_ok(bit cur, int v, int thr, int hys);
    if (cur) return !(v < thr);
    return v > thr + hys;
  endfunction

  function automatic bit upper_trip(bit cur, int v, int thr, int hys);
    if (cur) return v >= thr - hys;
    return v > thr;
  endfunction

  function automatic int phase_len(int lim);
    return (lim < 1) ? 1 : lim;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_uv <= 0; m_ov <= 0; m_st <= 0; m_age <= 0;
    end else begin
      bit nu, no;
      nu = lower_ok(m_uv, int'(vin), int'(uv_thr), int'(uv_hys));
      no = upper_trip(m_ov, int'(vin), int'(ov_thr), int'(ov_hys));
      m_uv <= nu; m_ov <= no;
      if (!(nu && !no)) begin m_st <= 0; m_age <= 0; end
      else if (en_n) begin m_st <= 1; m_age <= 0; end
      else if (m_st <= 1) begin m_st <= 2; m_age <= 0; end
      else if (m_st == 2) begin
        if (m_age + 1 >= phase_len(int'(t_on))) begin m_st <= 3; m_age <= 0; end
        else m_age <= m_age + 1;
      end else if (m_st == 3) begin
        if (m_age + 1 >= phase_len(int'(t_start))) begin m_st <= 4; m_age <= 0; end
        else m_age <= m_age + 1;
      end
    end
  end

  task automatic check_all();
    bit eg, ef;
    eg = (m_st == 3) || (m_st == 4);
    ef = (m_st == 1) || (m_st == 4);
    checks++;
    if (int'(status) != m_st || gate_on !== eg || flag_n !== ef) begin
      errors++;
      $display("FAIL %s: status=%0d gate=%b flag_n=%b expected status=%0d gate=%b flag_n=%b",
               tag, status, gate_on, flag_n, m_st, eg, ef);
    end
  endtask

  task automatic tick(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check_all();
    end
  endtask

  task automatic expect_status(int exp, string t);
    checks++;
    if (int'(status) != exp) begin
      errors++;
      $display("FAIL %s: status=%0d expected %0d", t, status, exp);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    // R1: reset state
    tag = "R1";
    vin = 10'd500;
    tick(3);
    expect_status(0, "R1");
    rst = 1'b0;
    // R5/R6 on a clean valid input: count 6 then wait 4
    tag = "R5";
    tick(1); expect_status(2, "R5");
    tick(6); expect_status(3, "R5");
    tag = "R6";
    tick(4); expect_status(4, "R6");
    // R3: lower hysteresis
    tag = "R3";
    vin = 10'd305; tick(2); expect_status(4, "R3");
    vin = 10'd300; tick(1); expect_status(4, "R3");
    vin = 10'd299; tick(1); expect_status(0, "R3");
    vin = 10'd310; tick(2); expect_status(0, "R3");
    vin = 10'd320; tick(2); expect_status(0, "R3");
    vin = 10'd321; tick(1); expect_status(2, "R3");
    tick(12);
    // R4: upper hysteresis
    tag = "R4";
    vin = 10'd700; tick(1); expect_status(4, "R4");
    vin = 10'd701; tick(1); expect_status(0, "R4");
    vin = 10'd670; tick(2); expect_status(0, "R4");
    vin = 10'd669; tick(1); expect_status(2, "R4");
    tick(12);
    // R7: glitch during each delay restarts
    tag = "R7";
    vin = 10'd200; tick(1);
    vin = 10'd500; tick(4);
    vin = 10'd800; tick(1); expect_status(0, "R7");
    vin = 10'd500; tick(6); expect_status(2, "R7");
    tick(2); expect_status(3, "R7");
    vin = 10'd250; tick(1); expect_status(0, "R7");
    vin = 10'd500; tick(7); expect_status(3, "R7");
    tick(5);
    // R8: shutdown with valid and invalid input
    tag = "R8";
    en_n = 1'b1; tick(1); expect_status(1, "R8");
    vin = 10'd900; tick(1); expect_status(0, "R8");
    vin = 10'd500; tick(2); expect_status(1, "R8");
    vin = 10'd100; tick(1); expect_status(0, "R8");
    vin = 10'd500; tick(2);
    // R9: re-enable restarts the full sequence
    tag = "R9";
    en_n = 1'b0; tick(1); expect_status(2, "R9");
    tick(6); expect_status(3, "R9");
    tick(4); expect_status(4, "R9");
    // R5/R6 zero delays behave as one cycle
    tag = "R5";
    t_on = 16'd0; t_start = 16'd0;
    en_n = 1'b1; tick(1); en_n = 1'b0;
    tick(1); expect_status(2, "R5");
    tick(1); expect_status(3, "R6");
    tick(1); expect_status(4, "R6");
    // R10: random mix, full model comparison every cycle
    tag = "R10";
    for (int k = 0; k < 4000; k++) begin
      if ($urandom_range(0, 3) == 0) begin
        case ($urandom_range(0, 3))
          0: vin = CODE_W'($urandom_range(280, 330));
          1: vin = CODE_W'($urandom_range(660, 720));
          2: vin = CODE_W'($urandom_range(340, 650));
          default: vin = CODE_W'($urandom_range(0, 1023));
        endcase
      end
      if ($urandom_range(0, 40) == 0) en_n = ~en_n;
      if ($urandom_range(0, 150) == 0) begin
        t_on = CNT_W'($urandom_range(0, 9));
        t_start = CNT_W'($urandom_range(0, 9));
      end
      tick(1);
    end
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule